// File: doc/BRIEF.md
# Buffer Release Action Engine

This block decides what happens to each item handed back for release. A request brings a kind code that says whether the pointer names a plain buffer or one of several descriptor kinds. It also brings an action code, the pointer itself, and a start index. The engine then does one of four things. It returns the item to the buffer idle list or to the link idle list. It forwards the item to firmware. It raises an internal-error strobe that carries the offending request. Or, for a partial release, it walks a small link descriptor held in a local array of pointer slots.

A partial release frees the buffer pointers of one frame. It starts at the given slot and frees one slot per clock, overwriting each freed slot with zero, the null pointer. The walk stops at a slot that is already null, at a slot carrying a last-in-frame marker, or at the final slot. When no non-null slot is left after the walk, the descriptor itself goes to the link idle list. The slot array is loaded through a write port and can be observed through a read port. Requests use a valid/ready handshake, and ready stays low for the whole walk.

Top module: `buf_release_engine`

## Requirements
- R1: After reset, req_ready is 1, all strobes (buf_push, link_push, fw_fwd, err_flag) are 0 and every slot reads 0.
- R2: Kind 0 (buffer) with action 0 gives buf_push with the request pointer one cycle after acceptance.
- R3: Kinds 1 (buffer link), 2 (frame link) and 4 (queue extension) with action 0 give link_push with the request pointer one cycle after acceptance, and no slot is touched.
- R4: Kind 3 (extension descriptor) gives fw_fwd with the request pointer one cycle after acceptance, whatever the action code.
- R5: Kind codes 5 to 7 give err_flag, with err_kind, err_act and err_ptr equal to the request, one cycle after acceptance.
- R6: Action code 2 or higher with any kind other than 3 gives err_flag.
- R7: Action 1 with kind 0, 2 or 4 gives err_flag.
- R8: Kind 1 with action 1 starts a walk at slot req_first. One clock after acceptance the first slot is handled, then one slot per clock. Each non-null slot gives buf_push with its pointer and is cleared to 0.
- R9: The walk ends on the first slot that is null (no push for it), on a slot whose last marker is set (after freeing it), or at slot NSLOT-1. Slots outside the walked range keep their values.
- R10: In the cycle that shows the end of a walk, link_push carries the descriptor pointer exactly when every slot is null, and is 0 otherwise.
- R11: While a walk is in progress req_ready is 0, and a request held valid during that time is not accepted.
- R12: A request outside a walk produces exactly one of buf_push, link_push, fw_fwd and err_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine can accept a request |
| req_kind | input | 3 | Buffer/descriptor kind code |
| req_act | input | 3 | Action code |
| req_ptr | input | PTR_W | Pointer of the released item |
| req_first | input | IDX_W | Start slot for a partial release |
| slot_wr_en | input | 1 | Write one descriptor slot (ignored during a walk) |
| slot_wr_idx | input | IDX_W | Slot to write |
| slot_wr_ptr | input | PTR_W | Pointer written to the slot |
| slot_wr_last | input | 1 | Last-in-frame marker written to the slot |
| slot_rd_idx | input | IDX_W | Slot to observe |
| slot_rd_ptr | output | PTR_W | Pointer held in the observed slot |
| buf_push | output | 1 | Push strobe to the buffer idle list |
| buf_push_ptr | output | PTR_W | Pointer pushed to the buffer idle list |
| link_push | output | 1 | Push strobe to the link idle list |
| link_push_ptr | output | PTR_W | Pointer pushed to the link idle list |
| fw_fwd | output | 1 | Forward-to-firmware strobe |
| fw_fwd_ptr | output | PTR_W | Forwarded pointer |
| err_flag | output | 1 | Internal-error strobe |
| err_kind | output | 3 | Kind code of the erroneous request |
| err_act | output | 3 | Action code of the erroneous request |
| err_ptr | output | PTR_W | Pointer of the erroneous request |

## Verification
A direct outcome (buffer push, link push, forward or error) is due in the cycle after the accepting edge. The bench drives each request at a falling edge and samples the strobes at the very next falling edge. For a walk, the first slot result appears one cycle later than that, and each further slot one cycle after the one before. The bench steps its own slot model in that order and compares at every falling edge, including the descriptor release in the final step. One more cycle after the walk confirms that a request held valid throughout was never taken, and the read port then confirms which slots were cleared.

// File: rtl/brel_pkg.sv
package brel_pkg;

    localparam int KIND_W = 3;
    localparam int ACT_W  = 3;

    localparam logic [KIND_W-1:0] KIND_BUF  = 3'd0;
    localparam logic [KIND_W-1:0] KIND_BLNK = 3'd1;
    localparam logic [KIND_W-1:0] KIND_FLNK = 3'd2;
    localparam logic [KIND_W-1:0] KIND_EXT  = 3'd3;
    localparam logic [KIND_W-1:0] KIND_QEXT = 3'd4;

    localparam logic [ACT_W-1:0] ACT_RETURN = 3'd0;
    localparam logic [ACT_W-1:0] ACT_PART   = 3'd1;

    typedef enum logic [2:0] {
        OUT_BUF  = 3'd0,
        OUT_LINK = 3'd1,
        OUT_FWD  = 3'd2,
        OUT_ERR  = 3'd3,
        OUT_WALK = 3'd4
    } outcome_e;

endpackage

// File: rtl/brel_classify.sv
module brel_classify
    import brel_pkg::*;
(
    input  logic [KIND_W-1:0] kind,
    input  logic [ACT_W-1:0]  act,
    output outcome_e          outcome
);
    always_comb begin
        if (kind > KIND_QEXT) begin
            outcome = OUT_ERR;
        end else if (kind == KIND_EXT) begin
            outcome = OUT_FWD;
        end else if (act == ACT_RETURN) begin
            outcome = (kind == KIND_BUF) ? OUT_BUF : OUT_LINK;
        end else if (act == ACT_PART && kind == KIND_BLNK) begin
            outcome = OUT_WALK;
        end else begin
            outcome = OUT_ERR;
        end
    end
endmodule

// File: rtl/brel_null_scan.sv
module brel_null_scan #(
    parameter int NSLOT = 8,
    parameter int PTR_W = 16,
    localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic [NSLOT-1:0][PTR_W-1:0] ptrs,
    input  logic [IDX_W-1:0]            skip_idx,
    output logic                        others_null
);
    logic [NSLOT-1:0] live;

    for (genvar j = 0; j < NSLOT; j++) begin : g_slot
        assign live[j] = (|ptrs[j]) && (skip_idx != IDX_W'(j));
    end

    assign others_null = ~|live;
endmodule

// File: rtl/buf_release_engine.sv
module buf_release_engine
    import brel_pkg::*;
#(
    parameter int NSLOT = 8,
    parameter int PTR_W = 16,
    localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [KIND_W-1:0] req_kind,
    input  logic [ACT_W-1:0]  req_act,
    input  logic [PTR_W-1:0]  req_ptr,
    input  logic [IDX_W-1:0]  req_first,
    input  logic              slot_wr_en,
    input  logic [IDX_W-1:0]  slot_wr_idx,
    input  logic [PTR_W-1:0]  slot_wr_ptr,
    input  logic              slot_wr_last,
    input  logic [IDX_W-1:0]  slot_rd_idx,
    output logic [PTR_W-1:0]  slot_rd_ptr,
    output logic              buf_push,
    output logic [PTR_W-1:0]  buf_push_ptr,
    output logic              link_push,
    output logic [PTR_W-1:0]  link_push_ptr,
    output logic              fw_fwd,
    output logic [PTR_W-1:0]  fw_fwd_ptr,
    output logic              err_flag,
    output logic [KIND_W-1:0] err_kind,
    output logic [ACT_W-1:0]  err_act,
    output logic [PTR_W-1:0]  err_ptr
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSLOT - 1);

    typedef struct packed {
        logic                        walking;
        logic [IDX_W-1:0]            idx;
        logic [PTR_W-1:0]            desc_ptr;
        logic [NSLOT-1:0][PTR_W-1:0] ptrs;
        logic [NSLOT-1:0]            last;
        logic                        buf_v;
        logic [PTR_W-1:0]            buf_p;
        logic                        link_v;
        logic [PTR_W-1:0]            link_p;
        logic                        fw_v;
        logic [PTR_W-1:0]            fw_p;
        logic                        err_v;
        logic [KIND_W-1:0]           err_k;
        logic [ACT_W-1:0]            err_a;
        logic [PTR_W-1:0]            err_p;
    } state_t;

    state_t   st_d, st_q;
    outcome_e outcome;
    logic     others_null;
    logic     accept;

    brel_classify u_classify (
        .kind    (req_kind),
        .act     (req_act),
        .outcome (outcome)
    );

    brel_null_scan #(.NSLOT(NSLOT), .PTR_W(PTR_W)) u_scan (
        .ptrs        (st_q.ptrs),
        .skip_idx    (st_q.idx),
        .others_null (others_null)
    );

    assign req_ready = !st_q.walking;
    assign accept    = req_valid && req_ready;

    always_comb begin
        logic [PTR_W-1:0] cur;
        logic             stop;
        st_d        = st_q;
        st_d.buf_v  = 1'b0;
        st_d.link_v = 1'b0;
        st_d.fw_v   = 1'b0;
        st_d.err_v  = 1'b0;
        cur         = st_q.ptrs[st_q.idx];
        stop        = 1'b0;
        if (!st_q.walking) begin
            if (slot_wr_en) begin
                st_d.ptrs[slot_wr_idx] = slot_wr_ptr;
                st_d.last[slot_wr_idx] = slot_wr_last;
            end
            if (accept) begin
                case (outcome)
                    OUT_BUF: begin
                        st_d.buf_v = 1'b1;
                        st_d.buf_p = req_ptr;
                    end
                    OUT_LINK: begin
                        st_d.link_v = 1'b1;
                        st_d.link_p = req_ptr;
                    end
                    OUT_FWD: begin
                        st_d.fw_v = 1'b1;
                        st_d.fw_p = req_ptr;
                    end
                    OUT_WALK: begin
                        st_d.walking  = 1'b1;
                        st_d.idx      = req_first;
                        st_d.desc_ptr = req_ptr;
                    end
                    default: begin
                        st_d.err_v = 1'b1;
                        st_d.err_k = req_kind;
                        st_d.err_a = req_act;
                        st_d.err_p = req_ptr;
                    end
                endcase
            end
        end else begin
            if (cur == '0) begin
                stop = 1'b1;
            end else begin
                st_d.buf_v             = 1'b1;
                st_d.buf_p             = cur;
                st_d.ptrs[st_q.idx]    = '0;
                st_d.last[st_q.idx]    = 1'b0;
                stop = st_q.last[st_q.idx] || (st_q.idx == LAST_IDX);
            end
            if (stop) begin
                st_d.walking = 1'b0;
                if (others_null) begin
                    st_d.link_v = 1'b1;
                    st_d.link_p = st_q.desc_ptr;
                end
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot_rd_ptr   = st_q.ptrs[slot_rd_idx];
    assign buf_push      = st_q.buf_v;
    assign buf_push_ptr  = st_q.buf_p;
    assign link_push     = st_q.link_v;
    assign link_push_ptr = st_q.link_p;
    assign fw_fwd        = st_q.fw_v;
    assign fw_fwd_ptr    = st_q.fw_p;
    assign err_flag      = st_q.err_v;
    assign err_kind      = st_q.err_k;
    assign err_act       = st_q.err_a;
    assign err_ptr       = st_q.err_p;
endmodule

// File: rtl/brel_checker.sv
module brel_checker #(
    parameter int PTR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [2:0]       req_kind,
    input logic [2:0]       req_act,
    input logic [PTR_W-1:0] req_ptr,
    input logic             buf_push,
    input logic [PTR_W-1:0] buf_push_ptr,
    input logic             link_push,
    input logic             fw_fwd,
    input logic [PTR_W-1:0] fw_fwd_ptr,
    input logic             err_flag
);
    logic acc;
    assign acc = req_valid && req_ready;

    assert_buf_return_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_kind == 3'd0 && req_act == 3'd0)
        |=> (buf_push && buf_push_ptr == $past(req_ptr)));

    assert_ext_forward_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_kind == 3'd3) |=> (fw_fwd && fw_fwd_ptr == $past(req_ptr)));

    assert_bad_kind_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_kind > 3'd4) |=> err_flag);

    assert_walk_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_kind == 3'd1 && req_act == 3'd1) |=> !req_ready);

    assert_single_outcome_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fw_fwd, err_flag, link_push}) && $onehot0({fw_fwd, err_flag, buf_push}));
endmodule

bind buf_release_engine brel_checker #(.PTR_W(PTR_W)) u_brel_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_kind     (req_kind),
    .req_act      (req_act),
    .req_ptr      (req_ptr),
    .buf_push     (buf_push),
    .buf_push_ptr (buf_push_ptr),
    .link_push    (link_push),
    .fw_fwd       (fw_fwd),
    .fw_fwd_ptr   (fw_fwd_ptr),
    .err_flag     (err_flag)
);

// File: tb/tb_buf_release_engine.sv
`timescale 1ns/1ps
module tb_buf_release_engine;
    localparam int NSLOT = 8;
    localparam int PTR_W = 16;
    localparam int IDX_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [2:0]       req_kind = '0;
    logic [2:0]       req_act = '0;
    logic [PTR_W-1:0] req_ptr = '0;
    logic [IDX_W-1:0] req_first = '0;
    logic             slot_wr_en = 1'b0;
    logic [IDX_W-1:0] slot_wr_idx = '0;
    logic [PTR_W-1:0] slot_wr_ptr = '0;
    logic             slot_wr_last = 1'b0;
    logic [IDX_W-1:0] slot_rd_idx = '0;
    logic [PTR_W-1:0] slot_rd_ptr;
    logic             buf_push, link_push, fw_fwd, err_flag;
    logic [PTR_W-1:0] buf_push_ptr, link_push_ptr, fw_fwd_ptr, err_ptr;
    logic [2:0]       err_kind, err_act;

    int checks = 0;
    int fails  = 0;
    logic [PTR_W-1:0] m_ptr [NSLOT];
    logic             m_last[NSLOT];

    always #10 clk = ~clk;

    buf_release_engine #(.NSLOT(NSLOT), .PTR_W(PTR_W)) dut (.*);

    task automatic chk(input bit ok, input string tag, input longint act_v, input longint exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
        end
    endtask

    // 0 buf, 1 link, 2 fwd, 3 err, 4 walk
    function automatic int exp_outcome(input logic [2:0] k, input logic [2:0] a);
        if (k > 3'd4) return 3;
        if (k == 3'd3) return 2;
        if (a == 3'd0) return (k == 3'd0) ? 0 : 1;
        if (a == 3'd1 && k == 3'd1) return 4;
        return 3;
    endfunction

    function automatic string err_tag(input logic [2:0] k, input logic [2:0] a);
        if (k > 3'd4) return "R5";
        if (a >= 3'd2) return "R6";
        return "R7";
    endfunction

    task automatic write_slot(input int i, input logic [PTR_W-1:0] p, input logic l);
        @(negedge clk);
        slot_wr_en = 1'b1; slot_wr_idx = IDX_W'(i); slot_wr_ptr = p; slot_wr_last = l;
        @(negedge clk);
        slot_wr_en = 1'b0;
        m_ptr[i] = p; m_last[i] = l;
    endtask

    task automatic check_slots(input string tag);
        for (int i = 0; i < NSLOT; i++) begin
            slot_rd_idx = IDX_W'(i);
            #1;
            chk(slot_rd_ptr == m_ptr[i], tag, slot_rd_ptr, m_ptr[i]);
        end
    endtask

    task automatic direct_req(input logic [2:0] k, input logic [2:0] a, input logic [PTR_W-1:0] p);
        int o;
        string t;
        o = exp_outcome(k, a);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_act = a; req_ptr = p;
        @(negedge clk);
        req_valid = 1'b0;
        t = (o == 0) ? "R2" : (o == 1) ? "R3" : (o == 2) ? "R4" : err_tag(k, a);
        chk(buf_push == (o == 0) && (o != 0 || buf_push_ptr == p), t, buf_push_ptr, p);
        chk(link_push == (o == 1) && (o != 1 || link_push_ptr == p), t, link_push_ptr, p);
        chk(fw_fwd == (o == 2) && (o != 2 || fw_fwd_ptr == p), t, fw_fwd_ptr, p);
        chk(err_flag == (o == 3) && (o != 3 || (err_ptr == p && err_kind == k && err_act == a)),
            t, {err_flag, err_kind, err_act, err_ptr}, {1'b1, k, a, p});
        chk($countones({buf_push, link_push, fw_fwd, err_flag}) == 1, "R12",
            {buf_push, link_push, fw_fwd, err_flag}, 1);
    endtask

    task automatic walk_req(input logic [PTR_W-1:0] dp, input int fi);
        bit stop, all_null;
        int i;
        logic [PTR_W-1:0] cur;
        @(negedge clk);
        req_valid = 1'b1; req_kind = 3'd1; req_act = 3'd1; req_ptr = dp; req_first = IDX_W'(fi);
        @(negedge clk);
        chk(!req_ready, "R11 busy after accept", req_ready, 0);
        chk(!buf_push && !link_push, "R8 no result before first slot", {buf_push, link_push}, 0);
        req_kind = 3'd0; req_act = 3'd0; req_ptr = 16'hDEC0;   // decoy held during walk
        i = fi; stop = 0;
        while (!stop) begin
            cur = m_ptr[i];
            @(negedge clk);
            if (cur == '0) begin
                stop = 1;
                chk(!buf_push, "R9 null slot stops without push", buf_push, 0);
            end else begin
                chk(buf_push && buf_push_ptr == cur, "R8 slot freed", buf_push_ptr, cur);
                stop = m_last[i] || (i == NSLOT - 1);
                m_ptr[i] = '0; m_last[i] = 1'b0;
            end
            if (stop) begin
                all_null = 1;
                for (int j = 0; j < NSLOT; j++) if (m_ptr[j] != '0) all_null = 0;
                chk(link_push == all_null && (!all_null || link_push_ptr == dp), "R10",
                    {link_push, link_push_ptr}, {all_null, dp});
                chk(req_ready, "R11 ready at walk end", req_ready, 1);
                req_valid = 1'b0;
            end else begin
                chk(!link_push && !req_ready, "R11 busy mid walk", {link_push, req_ready}, 0);
                i++;
            end
        end
        @(negedge clk);
        chk(!buf_push && !link_push && !fw_fwd && !err_flag, "R11 decoy not taken",
            {buf_push, link_push, fw_fwd, err_flag}, 0);
        check_slots("R9 slot contents after walk");
    endtask

    task automatic fill_random();
        for (int i = 0; i < NSLOT; i++) begin
            logic [PTR_W-1:0] p;
            p = ($urandom % 4 == 0) ? '0 : PTR_W'($urandom % 16'hFFFE + 1);
            write_slot(i, p, ($urandom % 4) == 0);
        end
    endtask

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NSLOT; i++) begin m_ptr[i] = '0; m_last[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready, "R1 ready", req_ready, 1);
        chk(!buf_push && !link_push && !fw_fwd && !err_flag, "R1 strobes",
            {buf_push, link_push, fw_fwd, err_flag}, 0);
        check_slots("R1 slots zero");

        // every non-walk kind/action pair
        for (int k = 0; k < 8; k++)
            for (int a = 0; a < 8; a++)
                if (exp_outcome(3'(k), 3'(a)) != 4)
                    direct_req(3'(k), 3'(a), PTR_W'(16'h1000 + k * 16 + a));

        // R3: link return leaves slots untouched
        write_slot(2, 16'h00A2, 1'b0);
        direct_req(3'd1, 3'd0, 16'h7777);
        check_slots("R3 slots kept");

        // walk from slot 2 to a last marker, other slots live: no release (R10)
        write_slot(3, 16'h00A3, 1'b0);
        write_slot(4, 16'h00A4, 1'b1);
        write_slot(6, 16'h00A6, 1'b0);
        walk_req(16'hD001, 2);
        // walk ending at the array end frees slot 6..7 region, then all null (R10)
        walk_req(16'hD002, 6);
        // walk starting on a null slot: no push, descriptor released (R9, R10)
        walk_req(16'hD003, 0);
        // walk to the end of the array with no marker (R9)
        for (int i = 0; i < NSLOT; i++) write_slot(i, PTR_W'(16'h0B00 + i), 1'b0);
        walk_req(16'hD004, 5);
        walk_req(16'hD005, 0);

        // random mix
        for (int n = 0; n < 300; n++) begin
            if ($urandom % 5 == 0) begin
                fill_random();
                walk_req(PTR_W'($urandom), int'($urandom % NSLOT));
            end else begin
                logic [2:0] k, a;
                k = 3'($urandom); a = 3'($urandom % 4);
                if (exp_outcome(k, a) == 4) walk_req(PTR_W'($urandom), int'($urandom % NSLOT));
                else direct_req(k, a, PTR_W'($urandom));
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule